// File: doc/BRIEF.md
# Row-Multiplexed LED Matrix Scan Timer

This block produces the timing for an eight-digit display built from 5x7 LED cells. All digits share the same seven row lines, and the rows are lit one at a time. The block steps through the rows and drives a one-hot row enable. It also produces a slow blink phase, and the column data path uses that phase to gate the column drivers of whole digits. Looking up the column data and driving the LEDs belong to other blocks.

Time advances on a selected tick rather than on a second clock. One input carries a tick from the local oscillator. The other carries a tick from a neighbouring display, so several displays can share one blink rhythm. A chain of four modulo counters turns the ticks into row steps, frames and blink phases. The chain runs as follows:

- a prescaler counts ticks, and it steps the row counter once every `PRE_DIV` ticks;
- the row counter counts the rows;
- a frame counter counts complete row cycles;
- a phase counter counts groups of frames.

The last of the `PHASE_DIV` phases is the off phase. At the start of each row period the row enables stay dark for a short time, so that the column lines can settle before the next row lights.

Top module: `dmx_scan_timer`

## Requirements
- R1: With `src_sel`=1 only `osc_tick` advances the chain. With `src_sel`=0 only `ext_tick` advances it. The input that is not selected has no effect.
- R2: The row index advances by one on the selected tick that completes each group of `PRE_DIV` ticks, counted from reset or clear.
- R3: `row_idx` stays in 0..`NROW`-1. After `NROW`-1 it returns to 0.
- R4: The frame counter advances only when the row index wraps. The phase counter advances once every `FRAME_DIV` frames. `blank_phase` is 1 exactly while the phase counter holds its last value, `PHASE_DIV`-1.
- R5: `row_en` is all zeros during the first `BLANK_TICKS` ticks of every row period. At all other times only bit `row_idx` is set.
- R6: While `blank_phase`=1 and `blink_en`=1, every bit of `col_gate` is 0.
- R7: While `blank_phase`=1, `flash_en`=1 and `blink_en`=0, `col_gate[d]` is 0 where `flash_mask[d]`=1 and 1 where it is 0.
- R8: While `blank_phase`=0, `col_gate` is all ones, whatever the attribute inputs are.
- R9: A `clr` of 1 sets every counter to 0 on the next clock edge and overrides a tick in the same cycle.
- R10: A `rst_n` of 0 sets every counter to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of all counters |
| src_sel | input | 1 | 1 selects the oscillator tick, 0 selects the external tick |
| osc_tick | input | 1 | Tick enable from the local oscillator |
| ext_tick | input | 1 | Tick enable from a neighbouring display |
| blink_en | input | 1 | Blank all digits during the off phase |
| flash_en | input | 1 | Blank the flagged digits during the off phase |
| flash_mask | input | NDIG | Per-digit flash flags |
| row_idx | output | ROW_W | Active row number |
| row_en | output | NROW | One-hot row enable with a dark interval |
| blank_phase | output | 1 | High during the off phase |
| col_gate | output | NDIG | Per-digit column enable |

## Verification
The bench builds the timer with `PRE_DIV`=4, `FRAME_DIV`=2 and `PHASE_DIV`=3. The row count stays at seven and the dark interval at one tick. With these values a full pass through all phases takes 168 ticks. The vector walk therefore wraps the row counter, reaches the off phase, leaves it again and wraps the phase counter, which the default dividers would only reach after more than 86,000 ticks. It also toggles the unselected tick input, so that an ignored source is seen to leave the row index and enables unchanged.

// File: rtl/scan_pkg.sv
package scan_pkg;
   // Bit width that holds a count of 0..m-1, never below one bit.
   function automatic int cnt_width(int m);
      return (m <= 2) ? 1 : $clog2(m);
   endfunction
endpackage

// File: rtl/scan_div_stage.sv
module scan_div_stage
   import scan_pkg::*;
#(
   parameter int MOD = 4,
   parameter int W   = cnt_width(MOD)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   output logic [W-1:0] count,
   output logic         wrap
);
   localparam logic [W-1:0] LAST = W'(MOD - 1);
   localparam bit POW2 = (MOD == (1 << W));

   if (MOD < 2) begin : g_bad_mod
      $error("scan_div_stage: MOD must be at least 2");
   end

   logic [W-1:0] count_q;
   logic [W-1:0] count_inc;

   assign wrap = en && (count_q == LAST);

   if (POW2) begin : g_free_wrap
      // Natural roll-over of the adder is the wrap.
      assign count_inc = count_q + 1'b1;
   end else begin : g_cmp_wrap
      assign count_inc = (count_q == LAST) ? '0 : count_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count_q <= '0;
      else if (clr)   count_q <= '0;
      else if (en)    count_q <= count_inc;
   end

   assign count = count_q;

   p_stage_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= LAST);
   p_stage_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(count_q));
   p_stage_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !clr) |=> (count_q == '0));
   p_stage_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count_q == '0));
endmodule

// File: rtl/scan_row_enable.sv
module scan_row_enable
   import scan_pkg::*;
#(
   parameter int NROW        = 7,
   parameter int PRE_DIV     = 32,
   parameter int BLANK_TICKS = 1,
   parameter int ROW_W       = cnt_width(NROW),
   parameter int PRE_W       = cnt_width(PRE_DIV)
) (
   input  logic [ROW_W-1:0] row_idx,
   input  logic [PRE_W-1:0] pre_cnt,
   output logic [NROW-1:0]  row_en
);
   localparam logic [PRE_W-1:0] DARK_END = PRE_W'(BLANK_TICKS);

   if (BLANK_TICKS >= PRE_DIV) begin : g_bad_dark
      $error("scan_row_enable: dark interval must be shorter than a row period");
   end

   logic lit;

   if (BLANK_TICKS == 0) begin : g_no_dark
      assign lit = 1'b1;
   end else begin : g_dark
      assign lit = (pre_cnt >= DARK_END);
   end

   for (genvar r = 0; r < NROW; r++) begin : g_row
      assign row_en[r] = lit && (row_idx == ROW_W'(r));
   end
endmodule

// File: rtl/scan_col_gate.sv
module scan_col_gate #(
   parameter int NDIG = 8
) (
   input  logic            blank_phase,
   input  logic            blink_en,
   input  logic            flash_en,
   input  logic [NDIG-1:0] flash_mask,
   output logic [NDIG-1:0] col_gate
);
   if (NDIG < 1) begin : g_bad_ndig
      $error("scan_col_gate: NDIG must be at least 1");
   end

   for (genvar d = 0; d < NDIG; d++) begin : g_dig
      logic dark;
      assign dark        = blank_phase && (blink_en || (flash_en && flash_mask[d]));
      assign col_gate[d] = !dark;
   end
endmodule

// File: rtl/dmx_scan_timer.sv
module dmx_scan_timer
   import scan_pkg::*;
#(
   parameter int NDIG        = 8,
   parameter int NROW        = 7,
   parameter int PRE_DIV     = 32,
   parameter int FRAME_DIV   = 128,
   parameter int PHASE_DIV   = 3,
   parameter int BLANK_TICKS = 1,
   parameter int ROW_W       = cnt_width(NROW)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             src_sel,
   input  logic             osc_tick,
   input  logic             ext_tick,
   input  logic             blink_en,
   input  logic             flash_en,
   input  logic [NDIG-1:0]  flash_mask,
   output logic [ROW_W-1:0] row_idx,
   output logic [NROW-1:0]  row_en,
   output logic             blank_phase,
   output logic [NDIG-1:0]  col_gate
);
   localparam int PRE_W   = cnt_width(PRE_DIV);
   localparam int FRAME_W = cnt_width(FRAME_DIV);
   localparam int PHASE_W = cnt_width(PHASE_DIV);
   localparam logic [PHASE_W-1:0] OFF_PHASE = PHASE_W'(PHASE_DIV - 1);
   localparam logic [ROW_W-1:0]   LAST_ROW  = ROW_W'(NROW - 1);

   if (NROW < 2 || PRE_DIV < 2 || FRAME_DIV < 2 || PHASE_DIV < 2) begin : g_bad_div
      $error("dmx_scan_timer: every divider must be at least 2");
   end

   // Clock source selection as a tick enable in the system clock domain.
   logic tick;
   assign tick = src_sel ? osc_tick : ext_tick;

   logic [PRE_W-1:0]   pre_cnt;
   logic [FRAME_W-1:0] frame_cnt;
   logic [PHASE_W-1:0] phase_cnt;
   logic pre_wrap, row_wrap, frame_wrap, phase_wrap;

   scan_div_stage #(.MOD(PRE_DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(tick),
      .count(pre_cnt), .wrap(pre_wrap));

   scan_div_stage #(.MOD(NROW)) u_row (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(pre_wrap),
      .count(row_idx), .wrap(row_wrap));

   scan_div_stage #(.MOD(FRAME_DIV)) u_frame (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(row_wrap),
      .count(frame_cnt), .wrap(frame_wrap));

   scan_div_stage #(.MOD(PHASE_DIV)) u_phase (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(frame_wrap),
      .count(phase_cnt), .wrap(phase_wrap));

   assign blank_phase = (phase_cnt == OFF_PHASE);

   scan_row_enable #(
      .NROW(NROW), .PRE_DIV(PRE_DIV), .BLANK_TICKS(BLANK_TICKS)
   ) u_rows (
      .row_idx(row_idx), .pre_cnt(pre_cnt), .row_en(row_en));

   scan_col_gate #(.NDIG(NDIG)) u_gate (
      .blank_phase(blank_phase), .blink_en(blink_en), .flash_en(flash_en),
      .flash_mask(flash_mask), .col_gate(col_gate));

   // Row sequencing and enables
   p_row_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_wrap && row_idx == LAST_ROW && !clr) |=> (row_idx == '0));
   p_row_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(row_en));
   p_row_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (BLANK_TICKS > 0 && row_idx != $past(row_idx)) |-> (row_en == '0));
   p_row_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clr) |=> $stable(row_idx));
   // Phase chain and column gating
   p_blank_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(blank_phase) |-> (frame_cnt == '0 && row_idx == '0));
   p_phase_roll_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_wrap && !clr) |=> !blank_phase);
   p_gate_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !blank_phase |-> (col_gate == '1));
   p_gate_blink_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (blank_phase && blink_en) |-> (col_gate == '0));
endmodule

// File: tb/dmx_scan_timer_tb.sv
module dmx_scan_timer_tb;
   localparam int NDIG = 8;
   localparam int NROW = 7;
   localparam int PRE  = 4;
   localparam int FDIV = 2;
   localparam int PDIV = 3;
   localparam int DARK = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 1'b0;
   logic src_sel = 1'b1, osc_tick = 1'b0, ext_tick = 1'b0;
   logic blink_en = 1'b0, flash_en = 1'b0;
   logic [NDIG-1:0] flash_mask = '0;
   logic [2:0] row_idx;
   logic [NROW-1:0] row_en;
   logic blank_phase;
   logic [NDIG-1:0] col_gate;

   int tests = 0;
   int fails = 0;
   int n = 0;          // selected ticks since reset or clear
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   dmx_scan_timer #(
      .NDIG(NDIG), .NROW(NROW), .PRE_DIV(PRE), .FRAME_DIV(FDIV),
      .PHASE_DIV(PDIV), .BLANK_TICKS(DARK)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .src_sel(src_sel),
      .osc_tick(osc_tick), .ext_tick(ext_tick), .blink_en(blink_en),
      .flash_en(flash_en), .flash_mask(flash_mask), .row_idx(row_idx),
      .row_en(row_en), .blank_phase(blank_phase), .col_gate(col_gate));

   // {sel, osc, ext, blink, flash, mask[7:0], reps[7:0]}
   localparam logic [20:0] VEC [8] = '{
      {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'd12},
      {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'd6},
      {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'd6},
      {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'd40},
      {1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'd70},
      {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'hA5, 8'd30},
      {1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h3C, 8'd30},
      {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 8'd4}
   };

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic check_state(string ctx);
      int pre, row, ph;
      logic blank;
      logic [NROW-1:0] ren;
      logic [NDIG-1:0] gate;
      pre = n % PRE;
      row = (n / PRE) % NROW;
      ph  = (n / (PRE * NROW * FDIV)) % PDIV;
      blank = (ph == PDIV - 1);
      ren = (pre < DARK) ? '0 : NROW'(1 << row);
      if (!blank) gate = '1;
      else if (blink_en) gate = '0;
      else if (flash_en) gate = ~flash_mask;
      else gate = '1;
      chk({ctx, " R2 R3 row_idx"}, 32'(row_idx), 32'(row));
      chk({ctx, " R5 row_en"}, 32'(row_en), 32'(ren));
      chk({ctx, " R4 blank_phase"}, 32'(blank_phase), 32'(blank));
      chk({ctx, " R6 R7 R8 col_gate"}, 32'(col_gate), 32'(gate));
   endtask

   task automatic cycle(logic sel, logic o, logic e, logic c);
      @(negedge clk);
      src_sel = sel; osc_tick = o; ext_tick = e; clr = c;
      @(posedge clk);
      if (c) n = 0;
      else if (sel ? o : e) n++;
      #2;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check_state("R10 reset");
      @(negedge clk);
      rst_n = 1'b1;

      // Vector walk: sources R1, chain R2..R4, gating R6..R8
      for (int v = 0; v < 8; v++) begin
         blink_en   = VEC[v][17];
         flash_en   = VEC[v][16];
         flash_mask = VEC[v][15:8];
         for (int k = 0; k < int'(VEC[v][7:0]); k++) begin
            cycle(VEC[v][20], VEC[v][19], VEC[v][18], 1'b0);
            check_state($sformatf("R1 vec%0d", v));
         end
      end

      // R9: clear overrides a simultaneous tick
      blink_en = 1'b0; flash_en = 1'b0; flash_mask = '0;
      for (int k = 0; k < 9; k++) cycle(1'b1, 1'b1, 1'b0, 1'b0);
      cycle(1'b1, 1'b1, 1'b0, 1'b1);
      chk("R9 clr row_idx", 32'(row_idx), 32'd0);
      chk("R9 clr row_en", 32'(row_en), 32'd0);
      check_state("R9 after clr");
      cycle(1'b1, 1'b1, 1'b0, 1'b0);
      check_state("R9 first tick");

      // R3: run into the row wrap and across it
      for (int k = 0; k < PRE * NROW + 2; k++) begin
         cycle(1'b1, 1'b1, 1'b0, 1'b0);
         check_state("R3 wrap");
      end

      // R10: asynchronous reset between edges
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      n = 0;
      chk("R10 async row_idx", 32'(row_idx), 32'd0);
      chk("R10 async row_en", 32'(row_en), 32'd0);
      chk("R10 async blank_phase", 32'(blank_phase), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      cycle(1'b1, 1'b1, 1'b0, 1'b0);
      check_state("R10 restart");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule